// File: doc/BRIEF.md
# Memory-Window Serial Flash Read Engine

This block turns each read that a bus master issues into a mapped address window into one complete serial-flash read transaction. It takes a request on a valid/ready channel and asserts chip select. It shifts out a read opcode and the address on one line, idles for a programmable number of dummy clocks, and gathers a 32-bit word on one, two or four data lines. It then deasserts chip select and hands the word back on a second valid/ready channel.

A 32-bit setup word chooses the read opcode, the address length, the dummy length and the data-line count. An ownership input decides who drives the flash pins. When it is high, this engine drives them. When it is low, the pins follow a register-driven frame engine that sits beside this block. A read that arrives while the window is not usable completes at once with an error flag and causes no pin activity. The window is unusable when the pins belong to the frame engine or when the setup word is all zero.

Back-pressure rules: a request is taken in the cycle where `req_valid` and `req_ready` are both high. The master must hold `req_valid` and `req_addr` until that cycle. Only one read is in flight at a time. `req_ready` stays low from acceptance until the response has been taken. The response is taken in the cycle where `rsp_valid` and `rsp_ready` are both high. Until then `rsp_data` and `rsp_err` stay unchanged. The serial clock runs at half the block clock, in mode 0: it idles low, outputs change while it is low, and inputs are sampled on its rising edge.

Top module: `flash_window_reader`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `spi_io_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read first sends setup bits [7:0] as the opcode. It then sends the low (setup[9:8]+1) bytes of `req_addr`, highest byte first. Every bit goes out MSB first on `spi_io_out[0]`, one bit per SCLK cycle.
- R3: After the address, the engine waits 8*setup[11:10] + setup[28:24] SCLK cycles before the data phase.
- R4: setup[13:12] selects the data lines. A value of 0 (or 2) means one line, read on `spi_io_in[1]`. A value of 1 means two lines on `spi_io_in[1:0]`. A value of 3 means four lines on `spi_io_in[3:0]`. The data phase lasts 32/lines SCLK cycles, and the first bits received are the word's most significant.
- R5: A successful read returns the gathered word on `rsp_data` with `rsp_err` at 0.
- R6: A read accepted while `map_owns_pins` is 0 returns `rsp_err`=1 and `rsp_data`=0 in the cycle after acceptance, and chip select never falls.
- R7: A read accepted while the setup word is all zero returns `rsp_err`=1 and `rsp_data`=0, with no chip-select activity.
- R8: While `map_owns_pins` is 0, the four `spi_*` outputs equal the matching `fe_*` inputs. While it is 1, they carry this engine's signals.
- R9: Chip select rises after the last data sample of every read and then stays high for at least one SCLK period (two clocks). SCLK is low whenever chip select is high.
- R10: `req_ready` is low while a response is pending. A held response keeps `rsp_valid`, `rsp_data` and `rsp_err` unchanged until `rsp_ready`.
- R11: Setup bits [23:16], the write opcode, have no effect on any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | 32 | Setup word (opcode, address length, dummy, lines, write opcode) |
| map_owns_pins | input | 1 | 1: this engine drives the flash pins; 0: frame engine does |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | ADDR_W | Byte address inside the window |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_data | output | 32 | Read word |
| rsp_err | output | 1 | Read refused (window unusable) |
| fe_sclk | input | 1 | Frame-engine serial clock |
| fe_cs_n | input | 1 | Frame-engine chip select |
| fe_io_out | input | 4 | Frame-engine data outputs |
| fe_io_oe | input | 4 | Frame-engine output enables |
| spi_sclk | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Chip select to flash, active low |
| spi_io_out | output | 4 | Data lines out |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_in | input | 4 | Data lines in |

## Verification
The checker takes for granted that the pin-ownership input does not change while this engine holds chip select low, because a switch mid-frame would hand a half-finished transaction to the other engine. The bench changes ownership and the setup word only between reads, when no response is pending. Its flash model changes `spi_io_in` only on a falling SCLK edge, one full block clock before the engine samples, so every sample sees settled data.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam int WORD_W = 32;
  localparam int HDR_W  = 40;
  localparam int CNT_W  = 7;

  typedef enum logic [1:0] {LANE_X1, LANE_X2, LANE_X4} lane_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DUMMY, ST_DATA, ST_GAP, ST_RESP
  } seq_state_e;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [4:0] dummy_bits;
    logic [7:0] wr_op;
    logic [1:0] rsv_mid;
    logic [1:0] lane_sel;
    logic [1:0] dummy_bytes;
    logic [1:0] addr_len;
    logic [7:0] rd_op;
  } setup_t;
endpackage

// File: rtl/fwr_setup_decode.sv
module fwr_setup_decode
  import fwr_pkg::*;
(
  input  logic [31:0]      setup_word,
  output logic             cfg_ok,
  output logic [7:0]       rd_op,
  output logic [1:0]       addr_len,
  output logic [CNT_W-1:0] hdr_bits,
  output logic [CNT_W-1:0] dummy_cycles,
  output lane_e            lanes
);
  setup_t s;
  assign s = setup_t'(setup_word);

  assign cfg_ok   = |setup_word;
  assign rd_op    = s.rd_op;
  assign addr_len = s.addr_len;

  always_comb begin
    hdr_bits     = CNT_W'(8) + CNT_W'({s.addr_len, 3'b000}) + CNT_W'(8);
    dummy_cycles = CNT_W'({s.dummy_bytes, 3'b000}) + CNT_W'(s.dummy_bits);
    case (s.lane_sel)
      2'b01:   lanes = LANE_X2;
      2'b11:   lanes = LANE_X4;
      default: lanes = LANE_X1;
    endcase
  end
endmodule

// File: rtl/fwr_sequencer.sv
module fwr_sequencer
  import fwr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CS_GAP_SCLK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              window_ok,
  input  logic [7:0]        rd_op,
  input  logic [1:0]        addr_len,
  input  logic [CNT_W-1:0]  hdr_bits,
  input  logic [CNT_W-1:0]  dummy_cycles,
  input  lane_e             lanes,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              eng_sclk,
  output logic              eng_cs_n,
  output logic [3:0]        eng_io_out,
  output logic [3:0]        eng_io_oe,
  input  logic [3:0]        io_in
);
  localparam int GAP_CLKS = 2 * CS_GAP_SCLK;

  seq_state_e        st;
  logic              sclk_q;
  logic              cs_n_q;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  sh;
  logic [WORD_W-1:0] din;
  logic              err_q;
  lane_e             lane_q;
  logic [CNT_W-1:0]  dummy_q;
  logic [CNT_W-1:0]  data_cycles;
  logic [31:0]       addr32;
  logic [31:0]       addr_aligned;
  logic [WORD_W-1:0] din_next;

  assign addr32       = 32'(req_addr);
  assign addr_aligned = addr32 << {(2'd3 - addr_len), 3'b000};

  always_comb begin
    case (lane_q)
      LANE_X2: begin
        data_cycles = CNT_W'(WORD_W / 2);
        din_next    = {din[WORD_W-3:0], io_in[1:0]};
      end
      LANE_X4: begin
        data_cycles = CNT_W'(WORD_W / 4);
        din_next    = {din[WORD_W-5:0], io_in[3:0]};
      end
      default: begin
        data_cycles = CNT_W'(WORD_W);
        din_next    = {din[WORD_W-2:0], io_in[1]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      din     <= '0;
      err_q   <= 1'b0;
      lane_q  <= LANE_X1;
      dummy_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (!window_ok) begin
              err_q <= 1'b1;
              din   <= '0;
              st    <= ST_RESP;
            end else begin
              err_q   <= 1'b0;
              cs_n_q  <= 1'b0;
              sh      <= {rd_op, addr_aligned};
              cnt     <= hdr_bits;
              lane_q  <= lanes;
              dummy_q <= dummy_cycles;
              st      <= ST_HDR;
            end
          end
        end
        ST_HDR, ST_DUMMY, ST_DATA: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (st == ST_DATA) din <= din_next;
          end else begin
            sclk_q <= 1'b0;
            if (cnt == CNT_W'(1)) begin
              case (st)
                ST_HDR: begin
                  if (dummy_q != '0) begin
                    st  <= ST_DUMMY;
                    cnt <= dummy_q;
                  end else begin
                    st  <= ST_DATA;
                    cnt <= data_cycles;
                  end
                end
                ST_DUMMY: begin
                  st  <= ST_DATA;
                  cnt <= data_cycles;
                end
                default: begin
                  st     <= ST_GAP;
                  cs_n_q <= 1'b1;
                  cnt    <= CNT_W'(GAP_CLKS);
                end
              endcase
            end else begin
              cnt <= cnt - CNT_W'(1);
              if (st == ST_HDR) sh <= {sh[HDR_W-2:0], 1'b0};
            end
          end
        end
        ST_GAP: begin
          if (cnt <= CNT_W'(1)) st <= ST_RESP;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_data  = din;
  assign rsp_err   = err_q;
  assign eng_sclk  = sclk_q;
  assign eng_cs_n  = cs_n_q;

  always_comb begin
    eng_io_out = 4'b0000;
    eng_io_oe  = 4'b0000;
    if (st == ST_HDR) begin
      eng_io_out[0] = sh[HDR_W-1];
      eng_io_oe     = 4'b0001;
    end else if (st == ST_DUMMY) begin
      eng_io_oe = 4'b0001;
    end else if (st == ST_DATA && lane_q == LANE_X1) begin
      eng_io_oe = 4'b0001;
    end
  end
endmodule

// File: rtl/fwr_pin_mux.sv
module fwr_pin_mux #(
  parameter int IO_W = 4
) (
  input  logic            map_sel,
  input  logic            eng_sclk,
  input  logic            eng_cs_n,
  input  logic [IO_W-1:0] eng_io_out,
  input  logic [IO_W-1:0] eng_io_oe,
  input  logic            fe_sclk,
  input  logic            fe_cs_n,
  input  logic [IO_W-1:0] fe_io_out,
  input  logic [IO_W-1:0] fe_io_oe,
  output logic            pin_sclk,
  output logic            pin_cs_n,
  output logic [IO_W-1:0] pin_io_out,
  output logic [IO_W-1:0] pin_io_oe
);
  assign pin_sclk   = map_sel ? eng_sclk   : fe_sclk;
  assign pin_cs_n   = map_sel ? eng_cs_n   : fe_cs_n;
  assign pin_io_out = map_sel ? eng_io_out : fe_io_out;
  assign pin_io_oe  = map_sel ? eng_io_oe  : fe_io_oe;
endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
  import fwr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CS_GAP_SCLK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_setup,
  input  logic              map_owns_pins,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              fe_sclk,
  input  logic              fe_cs_n,
  input  logic [3:0]        fe_io_out,
  input  logic [3:0]        fe_io_oe,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  logic             cfg_ok;
  logic [7:0]       rd_op;
  logic [1:0]       addr_len;
  logic [CNT_W-1:0] hdr_bits;
  logic [CNT_W-1:0] dummy_cycles;
  lane_e            lanes;
  logic             eng_sclk;
  logic             eng_cs_n;
  logic [3:0]       eng_io_out;
  logic [3:0]       eng_io_oe;

  fwr_setup_decode u_dec (
    .setup_word   (cfg_setup),
    .cfg_ok       (cfg_ok),
    .rd_op        (rd_op),
    .addr_len     (addr_len),
    .hdr_bits     (hdr_bits),
    .dummy_cycles (dummy_cycles),
    .lanes        (lanes)
  );

  fwr_sequencer #(
    .ADDR_W      (ADDR_W),
    .CS_GAP_SCLK (CS_GAP_SCLK)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .window_ok    (cfg_ok & map_owns_pins),
    .rd_op        (rd_op),
    .addr_len     (addr_len),
    .hdr_bits     (hdr_bits),
    .dummy_cycles (dummy_cycles),
    .lanes        (lanes),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .eng_sclk     (eng_sclk),
    .eng_cs_n     (eng_cs_n),
    .eng_io_out   (eng_io_out),
    .eng_io_oe    (eng_io_oe),
    .io_in        (spi_io_in)
  );

  fwr_pin_mux #(.IO_W(4)) u_mux (
    .map_sel    (map_owns_pins),
    .eng_sclk   (eng_sclk),
    .eng_cs_n   (eng_cs_n),
    .eng_io_out (eng_io_out),
    .eng_io_oe  (eng_io_oe),
    .fe_sclk    (fe_sclk),
    .fe_cs_n    (fe_cs_n),
    .fe_io_out  (fe_io_out),
    .fe_io_oe   (fe_io_oe),
    .pin_sclk   (spi_sclk),
    .pin_cs_n   (spi_cs_n),
    .pin_io_out (spi_io_out),
    .pin_io_oe  (spi_io_oe)
  );
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        map_owns_pins,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rsp_err,
  input logic        eng_cs_n,
  input logic        eng_sclk
);
  // R6: refused read answers one cycle after acceptance, with error
  p_refuse_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !map_owns_pins) |=> (rsp_valid && rsp_err && rsp_data == 32'd0));

  // R10: held response stays stable
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R10: no new request taken while a response waits
  p_no_accept_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: chip select stays high for at least two clocks after rising
  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_cs_n) |=> eng_cs_n);

  // R9: serial clock idles low while deselected
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cs_n |-> !eng_sclk);

  // R8: input assumption - ownership held while engine frame is open
  p_owner_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_cs_n |-> (map_owns_pins && $stable(map_owns_pins)));
endmodule

bind flash_window_reader fwr_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .map_owns_pins (map_owns_pins),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_err       (rsp_err),
  .eng_cs_n      (eng_cs_n),
  .eng_sclk      (eng_sclk)
);

// File: tb/flash_window_reader_test.sv
module flash_window_reader_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_setup = 32'h0;
  logic        map_owns_pins = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        fe_sclk = 1'b0;
  logic        fe_cs_n = 1'b1;
  logic [3:0]  fe_io_out = 4'h0;
  logic [3:0]  fe_io_oe = 4'h0;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic [3:0]  spi_io_out;
  logic [3:0]  spi_io_oe;
  logic [3:0]  spi_io_in = 4'h0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_window_reader uut (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .map_owns_pins(map_owns_pins),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .fe_sclk(fe_sclk), .fe_cs_n(fe_cs_n), .fe_io_out(fe_io_out), .fe_io_oe(fe_io_oe),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flash_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5AC33CA5;
  endfunction

  // flash model
  int          m_hdr = 40;
  int          m_dum = 0;
  int          m_w = 1;
  int          m_rises = 0;
  logic [39:0] m_cap = '0;
  logic [31:0] m_mask = 32'hFFFFFFFF;

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (m_rises < m_hdr) m_cap = {m_cap[38:0], spi_io_out[0]};
      m_rises++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && m_rises >= m_hdr + m_dum) begin
      automatic int j = m_rises - m_hdr - m_dum;
      automatic logic [31:0] wd = flash_word(m_cap[31:0] & m_mask) << (j * m_w);
      case (m_w)
        4:       spi_io_in = wd[31:28];
        2:       spi_io_in = {2'b00, wd[31:30]};
        default: spi_io_in = {2'b00, wd[31], 1'b0};
      endcase
    end
  end

  // pin monitors (engine ownership only)
  int hi_run = 100;
  int gap_bad = 0;
  int idle_clk_bad = 0;
  int cs_falls = 0;
  logic cs_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n && map_owns_pins) begin
      if (spi_cs_n) begin
        hi_run++;
        if (spi_sclk) idle_clk_bad++;
      end else begin
        if (cs_prev) begin
          cs_falls++;
          if (hi_run < 2) gap_bad++;
        end
        hi_run = 0;
      end
      cs_prev = spi_cs_n;
    end
  end

  task automatic issue(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic take_rsp;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic flash_read(input int mode, input int nab, input int db, input int dbits,
                            input logic [7:0] op, input logic [7:0] wop, input logic [31:0] a);
    automatic int w = (mode == 1) ? 2 : (mode == 3) ? 4 : 1;
    automatic logic [31:0] mask = (nab == 3) ? 32'hFFFFFFFF : ((32'h1 << (8*(nab+1))) - 1);
    automatic logic [39:0] exp_hdr = ({32'h0, op} << (8*(nab+1))) | {8'h0, a & mask};
    automatic logic [39:0] hdr_mask = (nab == 3) ? 40'hFF_FFFF_FFFF : ((40'h1 << (8*(nab+2))) - 1);
    cfg_setup = {3'b000, 5'(dbits), wop, 2'b00, 2'(mode), 2'(db), 2'(nab), op};
    m_hdr = 8 + 8*(nab+1);
    m_dum = 8*db + dbits;
    m_w = w;
    m_mask = mask;
    m_rises = 0;
    m_cap = '0;
    issue(a);
    wait_rsp();
    // R5 and R11: word matches regardless of write opcode field
    check("R5 R11 data", 64'(rsp_data), 64'(flash_word(a & mask)));
    check("R5 err", 64'(rsp_err), 64'd0);
    // R2: opcode and address bits seen by flash
    check("R2 header", 64'(m_cap & hdr_mask), 64'(exp_hdr));
    // R3 and R4: total SCLK cycles = header + dummy + 32/lines
    check("R3 R4 sclk count", 64'(m_rises), 64'(m_hdr + m_dum + 32/w));
    take_rsp();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cs_n", 64'(spi_cs_n), 64'd1);
    check("R1 sclk", 64'(spi_sclk), 64'd0);
    check("R1 oe", 64'(spi_io_oe), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: lines x address length x dummy bytes x dummy bits
    for (int mode = 0; mode < 4; mode++)
      for (int nab = 0; nab < 4; nab++)
        for (int db = 0; db < 2; db++)
          for (int k = 0; k < 2; k++) begin
            automatic int it = ((mode*4 + nab)*2 + db)*2 + k;
            flash_read(mode, nab, db, k*5, 8'(8'h03 + it*7), 8'(it*37 + 1),
                       32'hA1B2C3D4 ^ (32'(it) * 32'h01030507));
          end

    // R10: back-pressure on the response
    flash_read(3, 2, 1, 0, 8'h6C, 8'h12, 32'h00123456);
    m_rises = 0;
    issue(32'h00ABCDEF);
    wait_rsp();
    begin
      automatic logic [31:0] held = rsp_data;
      automatic int falls0 = cs_falls;
      repeat (8) @(negedge clk);
      check("R10 valid held", 64'(rsp_valid), 64'd1);
      check("R10 data held", 64'(rsp_data), 64'(held));
      check("R10 ready low", 64'(req_ready), 64'd0);
      check("R10 no new frame", 64'(cs_falls), 64'(falls0));
    end
    take_rsp();

    // R7: all-zero setup refused
    begin
      automatic int falls0 = cs_falls;
      cfg_setup = 32'h0;
      issue(32'h00001000);
      wait_rsp();
      check("R7 err", 64'(rsp_err), 64'd1);
      check("R7 data", 64'(rsp_data), 64'd0);
      check("R7 no cs", 64'(cs_falls), 64'(falls0));
      take_rsp();
    end

    // R6: pins owned by frame engine -> refused, no activity
    begin
      automatic int falls0 = cs_falls;
      cfg_setup = 32'h0012_0203;
      @(negedge clk);
      map_owns_pins = 1'b0;
      issue(32'h00002000);
      wait_rsp();
      check("R6 err", 64'(rsp_err), 64'd1);
      check("R6 data", 64'(rsp_data), 64'd0);
      check("R6 engine cs quiet", 64'(spi_cs_n), 64'd1);
      take_rsp();
      map_owns_pins = 1'b1;
      @(negedge clk);
      check("R6 no cs", 64'(cs_falls), 64'(falls0));
    end

    // R9: chip-select gap and idle clock over all frames
    check("R9 gap", 64'(gap_bad), 64'd0);
    check("R9 sclk idle", 64'(idle_clk_bad), 64'd0);

    // R8: pin ownership
    map_owns_pins = 1'b0;
    fe_sclk = 1'b1; fe_cs_n = 1'b0; fe_io_out = 4'hA; fe_io_oe = 4'hF;
    @(negedge clk);
    check("R8 fe pins", 64'({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe}),
          64'({1'b1, 1'b0, 4'hA, 4'hF}));
    map_owns_pins = 1'b1;
    @(negedge clk);
    check("R8 engine pins", 64'({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe}),
          64'({1'b0, 1'b1, 4'h0, 4'h0}));
    fe_sclk = 1'b0; fe_cs_n = 1'b1; fe_io_out = 4'h0; fe_io_oe = 4'h0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule